// File: doc/BRIEF.md
# Compact Two-Bit-Category RV32 Core

This block is a single-cycle processor for a reduced 32-bit RISC-V-like instruction set. Its encoding differs from the standard one. The two least significant bits of each instruction word pick one of four instruction categories. Bits [6:2] carry a 5-bit operation code within that category. Every instruction finishes in the clock cycle in which it is fetched. The core holds a 32-entry by 32-bit register file and a byte-addressed program counter that starts at 256.

The core fetches from an external word-addressed instruction memory and uses an external word-addressed data memory. Both memories read combinationally and write on the clock edge. The surrounding logic preloads both memories while the core is held in reset. It then releases reset and waits for the halted flag, which the core raises when it executes the break instruction. A retired-instruction counter and a combinational debug read port into the register file let the surrounding logic inspect the result.

Top module: `cq_core`

## Requirements
- R1: While `rst_n` is low, the core holds PC = 256 (so `imem_addr` = 64), `halted` = 0 and `retired` = 0, and every register reads as zero.
- R2: With bits [1:0] = 01, opcode 00000/00001/00010/00011 writes rd ([11:7]) with rs1+rs2, rs1−rs2, rs1&rs2 or rs1|rs2 respectively. rs1 is in bits [19:15] and rs2 in bits [24:20]. Sums and differences wrap modulo 2^32.
- R3: With bits [1:0] = 10 and imm = sign-extended bits [31:20], opcode 00000 writes rs1+imm, 00001 writes rs1&imm, 00010 writes rs1|imm, 00011 writes rs1 shifted left and 00100 writes rs1 shifted right arithmetically. Both shifts use only imm[4:0] as the shift amount.
- R4: Opcode 00101 in category 10 (load) and opcode 00011 in category 00 (store) use the byte address rs1 + sign-extended offset. The store offset is {[31:25],[11:7]}. The word index on the data port is that address divided by 4. The store drives the rs2 value with the write enable for one cycle.
- R5: In category 00, opcodes 00000, 00001 and 00010 branch when rs1 = rs2, rs1 ≠ rs2 and signed rs1 < rs2 respectively. A taken branch sets PC to PC + (sign-extended {[31:25],[11:7]} × 2). Otherwise PC advances by 4.
- R6: Category 11 opcode 00000 writes PC+4 into the rd named in the instruction and sets PC to PC + (sign-extended bits [31:12] × 2).
- R7: Category 11 opcode 11111 raises `halted`. From then until reset, the PC, the registers, the counter and the data memory no longer change, and no store is issued.
- R8: Register 0 always reads zero, and writes that target it are dropped.
- R9: `retired` rises by one for every executed instruction, the break instruction included.
- R10: `imem_addr` always presents PC divided by 4, and instructions run in address order unless a branch or jump redirects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | ADDR_W | Word index of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | ADDR_W | Word index for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the clock edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |
| halted | output | 1 | High once break has executed |
| retired | output | CNT_W | Executed-instruction count |
| dbg_sel | input | 5 | Register index for the debug port |
| dbg_val | output | 32 | Value of the selected register |

## Verification
Every result lands in the architectural registers within the cycle of its instruction. A wrong decode or ALU path therefore shows on the debug read port as soon as the program halts. A wrong branch or jump decision shows at once in the retired count and in the final fetch address, because the set of instructions that are skipped or executed changes. A stuck or leaky halt state shows within one cycle as a counter or fetch address that keeps moving, or as a data word that changes after the halt.

// File: rtl/cq_pkg.sv
// Shared encodings and control bundle for the category-coded core.
// Assumes 32-bit instruction and data words.
package cq_pkg;

    localparam int XW = 32;

    typedef enum logic [1:0] {
        CAT_FLOW = 2'b00,
        CAT_RR   = 2'b01,
        CAT_RI   = 2'b10,
        CAT_JMP  = 2'b11
    } cat_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLL,
        ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_EQ,
        BR_NE,
        BR_LT
    } br_kind_e;

    typedef struct packed {
        logic        wr_en;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        alu_op_e     alu_op;
        logic        use_imm;
        logic [XW-1:0] imm;
        logic        is_load;
        logic        is_store;
        logic        is_branch;
        br_kind_e    br_kind;
        logic        is_jal;
        logic        is_halt;
    } ctrl_t;

endpackage

// File: rtl/cq_decode.sv
// Instruction decoder: turns one word into the control bundle.
// Assumes func3/func7 fields are zero and not checked; unknown
// opcodes decode to a no-op that only advances the PC.
module cq_decode
    import cq_pkg::*;
(
    input  logic [XW-1:0] instr,
    output ctrl_t         ctrl
);

    logic [4:0]    op5;
    logic [XW-1:0] imm_s;
    logic [XW-1:0] imm_i;
    logic [XW-1:0] imm_j;

    // Field extraction and immediate sign extension
    always_comb begin
        op5   = instr[6:2];
        imm_s = {{(XW-12){instr[31]}}, instr[31:25], instr[11:7]};
        imm_i = {{(XW-12){instr[31]}}, instr[31:20]};
        imm_j = {{(XW-20){instr[31]}}, instr[31:12]};
    end

    // Category and opcode decode into control fields
    always_comb begin
        ctrl           = '0;
        ctrl.rd        = instr[11:7];
        ctrl.rs1       = instr[19:15];
        ctrl.rs2       = instr[24:20];
        ctrl.alu_op    = ALU_ADD;
        ctrl.br_kind   = BR_EQ;
        unique case (cat_e'(instr[1:0]))
            CAT_FLOW: begin
                ctrl.imm = imm_s;
                unique case (op5)
                    5'b00000: begin ctrl.is_branch = 1'b1; ctrl.br_kind = BR_EQ; end
                    5'b00001: begin ctrl.is_branch = 1'b1; ctrl.br_kind = BR_NE; end
                    5'b00010: begin ctrl.is_branch = 1'b1; ctrl.br_kind = BR_LT; end
                    5'b00011: begin ctrl.is_store = 1'b1; ctrl.use_imm = 1'b1; end
                    default: ;
                endcase
            end
            CAT_RR: begin
                unique case (op5)
                    5'b00000: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_ADD; end
                    5'b00001: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_SUB; end
                    5'b00010: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_AND; end
                    5'b00011: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_OR;  end
                    default: ;
                endcase
            end
            CAT_RI: begin
                ctrl.imm     = imm_i;
                ctrl.use_imm = 1'b1;
                unique case (op5)
                    5'b00000: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_ADD; end
                    5'b00001: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_AND; end
                    5'b00010: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_OR;  end
                    5'b00011: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_SLL; end
                    5'b00100: begin ctrl.wr_en = 1'b1; ctrl.alu_op = ALU_SRA; end
                    5'b00101: begin ctrl.wr_en = 1'b1; ctrl.is_load = 1'b1; end
                    default: ;
                endcase
            end
            CAT_JMP: begin
                ctrl.imm = imm_j;
                unique case (op5)
                    5'b00000: begin ctrl.wr_en = 1'b1; ctrl.is_jal = 1'b1; end
                    5'b11111: ctrl.is_halt = 1'b1;
                    default: ;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/cq_regfile.sv
// Register file: two operand read ports, one debug read port, one
// write port. Entry 0 is a constant zero; writes to it are dropped.
// Synchronous active-low reset clears every entry.
module cq_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [IW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [IW-1:0] ra3,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs_q[g] = '0;
        end else begin : g_flop
            // One architectural register with its own write decode
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (we && (wa == IW'(g)))
                    regs_q[g] <= wd;
            end
        end
    end

    // Combinational read ports
    always_comb begin
        rd1 = regs_q[ra1];
        rd2 = regs_q[ra2];
        rd3 = regs_q[ra3];
    end

endmodule

// File: rtl/cq_alu.sv
// Integer ALU for add, subtract, bitwise and/or and the two shifts.
// Shift amount is taken from b[4:0] only.
module cq_alu
    import cq_pkg::*;
(
    input  alu_op_e       op,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic [XW-1:0] y
);

    logic [4:0] shamt;

    // Operation select
    always_comb begin
        shamt = b[4:0];
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLL: y = a << shamt;
            ALU_SRA: y = XW'($signed(a) >>> shamt);
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/cq_core.sv
// Single-cycle core for the category-coded instruction set.
// Assumes combinational-read memories that write at the clock edge,
// word-aligned load/store addresses and a program that ends in break.
// The PC, halt flag, counter and registers all reset to their initial
// values on a synchronous active-low reset.
module cq_core
    import cq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 32,
    parameter int NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'd256
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [XW-1:0]     imem_data,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic [XW-1:0]     dmem_wdata,
    output logic              dmem_we,
    input  logic [XW-1:0]     dmem_rdata,
    output logic              halted,
    output logic [CNT_W-1:0]  retired,
    input  logic [4:0]        dbg_sel,
    output logic [XW-1:0]     dbg_val
);

    localparam int RIW = $clog2(NREG);

    logic [XW-1:0]    pc_q;
    logic [XW-1:0]    pc_nxt;
    logic             halt_q;
    logic [CNT_W-1:0] ret_q;
    ctrl_t            ctrl;
    logic [XW-1:0]    rs1_v;
    logic [XW-1:0]    rs2_v;
    logic [XW-1:0]    opb;
    logic [XW-1:0]    alu_y;
    logic [XW-1:0]    wb_v;
    logic [XW-1:0]    pc_inc;
    logic [XW-1:0]    pc_rel;
    logic             take;
    logic             rf_we;

    cq_decode u_dec (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    cq_regfile #(.NREG(NREG), .W(XW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (RIW'(ctrl.rd)),
        .wd    (wb_v),
        .ra1   (RIW'(ctrl.rs1)),
        .rd1   (rs1_v),
        .ra2   (RIW'(ctrl.rs2)),
        .rd2   (rs2_v),
        .ra3   (RIW'(dbg_sel)),
        .rd3   (dbg_val)
    );

    cq_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rs1_v),
        .b  (opb),
        .y  (alu_y)
    );

    // Operand select, branch decision and write-back select
    always_comb begin
        opb    = ctrl.use_imm ? ctrl.imm : rs2_v;
        pc_inc = pc_q + 32'd4;
        pc_rel = pc_q + {ctrl.imm[XW-2:0], 1'b0};
        unique case (ctrl.br_kind)
            BR_EQ:   take = (rs1_v == rs2_v);
            BR_NE:   take = (rs1_v != rs2_v);
            BR_LT:   take = ($signed(rs1_v) < $signed(rs2_v));
            default: take = 1'b0;
        endcase
        if (ctrl.is_load)
            wb_v = dmem_rdata;
        else if (ctrl.is_jal)
            wb_v = pc_inc;
        else
            wb_v = alu_y;
    end

    // Next PC selection
    always_comb begin
        if (ctrl.is_halt)
            pc_nxt = pc_q;
        else if (ctrl.is_jal || (ctrl.is_branch && take))
            pc_nxt = pc_rel;
        else
            pc_nxt = pc_inc;
    end

    // Port drive and state-change gating by the halt flag
    always_comb begin
        rf_we      = ctrl.wr_en && !halt_q;
        imem_addr  = pc_q[ADDR_W+1:2];
        dmem_addr  = alu_y[ADDR_W+1:2];
        dmem_wdata = rs2_v;
        dmem_we    = ctrl.is_store && !halt_q;
        halted     = halt_q;
        retired    = ret_q;
    end

    // Program counter, halt flag and retirement counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            halt_q <= 1'b0;
            ret_q  <= '0;
        end else if (!halt_q) begin
            pc_q   <= pc_nxt;
            halt_q <= ctrl.is_halt;
            ret_q  <= ret_q + 1'b1;
        end
    end

endmodule

// File: rtl/cq_core_chk.sv
// Port-level checker for cq_core: halt behaviour, counter progress
// and the constant-zero register. Bound to every cq_core instance.
module cq_core_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] imem_addr,
    input logic              dmem_we,
    input logic              halted,
    input logic [CNT_W-1:0]  retired,
    input logic [4:0]        dbg_sel,
    input logic [31:0]       dbg_val
);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7
    halt_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we);

    // R7
    halt_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr));

    // R9
    retire_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(retired));

    // R9
    retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> retired == $past(retired) + 1'b1);

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == 5'd0) |-> (dbg_val == 32'd0));

endmodule

bind cq_core cq_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cq_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .halted    (halted),
    .retired   (retired),
    .dbg_sel   (dbg_sel),
    .dbg_val   (dbg_val)
);

// File: tb/test_cq_core.sv
// Bench: runs a straight-line program for every pair of a set of
// operand values, plus a loop program, and checks the registers, the
// data memory, the counter and the fetch address against arithmetic.
module test_cq_core;

    localparam int AW = 8;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [31:0]   imem_data;
    logic [AW-1:0] dmem_addr;
    logic [31:0]   dmem_wdata;
    logic          dmem_we;
    logic [31:0]   dmem_rdata;
    logic          halted;
    logic [CW-1:0] retired;
    logic [4:0]    dbg_sel = 5'd0;
    logic [31:0]   dbg_val;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cq_core #(.ADDR_W(AW), .CNT_W(CW)) i_cq_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .halted     (halted),
        .retired    (retired),
        .dbg_sel    (dbg_sel),
        .dbg_val    (dbg_val)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    function automatic logic [31:0] f_b(input logic [4:0] op, input logic [4:0] r1,
                                        input logic [4:0] r2, input logic [11:0] im);
        return {im[11:5], r2, r1, 3'b000, im[4:0], op, 2'b00};
    endfunction
    function automatic logic [31:0] f_r(input logic [4:0] op, input logic [4:0] rd,
                                        input logic [4:0] r1, input logic [4:0] r2);
        return {7'b0, r2, r1, 3'b000, rd, op, 2'b01};
    endfunction
    function automatic logic [31:0] f_i(input logic [4:0] op, input logic [4:0] rd,
                                        input logic [4:0] r1, input logic [11:0] im);
        return {im, r1, 3'b000, rd, op, 2'b10};
    endfunction
    function automatic logic [31:0] f_j(input logic [4:0] op, input logic [4:0] rd,
                                        input logic [19:0] im);
        return {im, rd, op, 2'b11};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        dbg_sel = 5'(idx);
        #1;
        v = dbg_val;
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 256; k++) begin
            imem[k] = 32'd0;
            dmem[k] = 32'd0;
        end
    endtask

    task automatic reset_core();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!halted && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!halted) chk(req, 32'd0, 32'd1);
    endtask

    logic [31:0] vals [7];

    initial begin : stim
        logic [31:0] v, a, b, ex;
        int s, ret_hold;
        vals[0] = 32'd0;          vals[1] = 32'd7;
        vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000;  vals[5] = -32'sd123456;
        vals[6] = 32'h1234_5678;

        // R1: reset state after holding reset
        clear_mem();
        reset_core();
        chk("R1 fetch", 32'(imem_addr), 32'd64);
        chk("R1 halted", 32'(halted), 32'd0);
        chk("R1 retired", retired, 32'd0);
        for (int r = 0; r < 32; r++) begin
            rd_reg(r, v);
            chk("R1 reg", v, 32'd0);
        end

        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                a = vals[i];
                b = vals[j];
                s = (i * 5 + j * 3) % 32;
                clear_mem();
                dmem[128] = a;
                dmem[129] = b;
                imem[64] = f_i(5'd5, 5'd1, 5'd0, 12'd512);
                imem[65] = f_i(5'd5, 5'd2, 5'd0, 12'd516);
                imem[66] = f_r(5'd0, 5'd3, 5'd1, 5'd2);
                imem[67] = f_r(5'd1, 5'd4, 5'd1, 5'd2);
                imem[68] = f_r(5'd2, 5'd5, 5'd1, 5'd2);
                imem[69] = f_r(5'd3, 5'd6, 5'd1, 5'd2);
                imem[70] = f_i(5'd0, 5'd7, 5'd1, 12'hFFB);
                imem[71] = f_i(5'd1, 5'd8, 5'd1, 12'h0F0);
                imem[72] = f_i(5'd2, 5'd9, 5'd1, 12'hF00);
                imem[73] = f_i(5'd3, 5'd10, 5'd1, {7'b0101010, 5'(s)});
                imem[74] = f_i(5'd4, 5'd11, 5'd1, {7'b1000001, 5'(s)});
                imem[75] = f_b(5'd3, 5'd0, 5'd3, 12'd520);
                imem[76] = f_i(5'd5, 5'd12, 5'd0, 12'd520);
                imem[77] = f_b(5'd2, 5'd1, 5'd2, 12'd4);
                imem[78] = f_i(5'd0, 5'd13, 5'd0, 12'd1);
                imem[79] = f_b(5'd0, 5'd1, 5'd2, 12'd4);
                imem[80] = f_i(5'd0, 5'd14, 5'd0, 12'd1);
                imem[81] = f_b(5'd1, 5'd1, 5'd2, 12'd4);
                imem[82] = f_i(5'd0, 5'd15, 5'd0, 12'd1);
                imem[83] = f_j(5'd0, 5'd16, 20'd4);
                imem[84] = f_i(5'd0, 5'd17, 5'd0, 12'd1);
                imem[85] = f_i(5'd0, 5'd0, 5'd0, 12'd7);
                imem[86] = f_j(5'd31, 5'd0, 20'd0);
                reset_core();
                run_to_halt("R7 halt reached");

                rd_reg(3, v);  chk("R2 add", v, a + b);
                rd_reg(4, v);  chk("R2 sub", v, a - b);
                rd_reg(5, v);  chk("R2 and", v, a & b);
                rd_reg(6, v);  chk("R2 or", v, a | b);
                rd_reg(7, v);  chk("R3 addi", v, a - 32'd5);
                rd_reg(8, v);  chk("R3 andi", v, a & 32'h0F0);
                rd_reg(9, v);  chk("R3 ori", v, a | 32'hFFFF_FF00);
                rd_reg(10, v); chk("R3 sll", v, a << s);
                ex = 32'($signed(a) >>> s);
                rd_reg(11, v); chk("R3 sra", v, ex);
                chk("R4 store", dmem[130], a + b);
                rd_reg(12, v); chk("R4 load", v, a + b);
                rd_reg(13, v); chk("R5 blt", v, ($signed(a) < $signed(b)) ? 32'd0 : 32'd1);
                rd_reg(14, v); chk("R5 beq", v, (a == b) ? 32'd0 : 32'd1);
                rd_reg(15, v); chk("R5 bne", v, (a != b) ? 32'd0 : 32'd1);
                rd_reg(16, v); chk("R6 link", v, 32'd336);
                rd_reg(17, v); chk("R6 skip", v, 32'd0);
                rd_reg(0, v);  chk("R8 x0", v, 32'd0);
                chk("R9 count", retired, ($signed(a) < $signed(b)) ? 32'd20 : 32'd21);
                chk("R10 fetch", 32'(imem_addr), 32'd86);
                ret_hold = int'(retired);
                repeat (5) @(negedge clk);
                chk("R7 counter frozen", retired, 32'(ret_hold));
                chk("R7 fetch frozen", 32'(imem_addr), 32'd86);
                chk("R7 data frozen", dmem[130], a + b);
                rd_reg(3, v);  chk("R7 reg frozen", v, a + b);
            end
        end

        // Loop program: backward branch, forward jal into x5
        clear_mem();
        imem[64] = f_i(5'd0, 5'd1, 5'd0, 12'd5);
        imem[65] = f_i(5'd0, 5'd2, 5'd2, 12'd3);
        imem[66] = f_i(5'd0, 5'd1, 5'd1, 12'hFFF);
        imem[67] = f_b(5'd1, 5'd1, 5'd0, 12'hFFC);
        imem[68] = f_j(5'd0, 5'd5, 20'd4);
        imem[69] = f_i(5'd0, 5'd6, 5'd0, 12'd9);
        imem[70] = f_j(5'd31, 5'd0, 20'd0);
        reset_core();
        rd_reg(2, v); chk("R1 regs cleared", v, 32'd0);
        run_to_halt("R7 loop halt");
        rd_reg(2, v); chk("R5 backward loop", v, 32'd15);
        rd_reg(1, v); chk("R5 loop count", v, 32'd0);
        rd_reg(5, v); chk("R6 link rd", v, 32'd276);
        rd_reg(6, v); chk("R6 jump skip", v, 32'd0);
        chk("R9 loop count", retired, 32'd18);
        chk("R10 loop fetch", 32'(imem_addr), 32'd70);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule